// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block produces the timing for a serial time-division-multiplexed bus from a single 65.536 MHz master clock. It drives a bus clock at 32.768 MHz or 16.384 MHz by dividing the master clock by 2 or 4. It also drives an 8 kHz frame pulse and strobes that tell downstream serializers where each bit period and each frame begins. A frame is always 8192 master cycles: 4096 bit periods at the fast rate, 2048 at the slow one.

The frame boundary is the falling edge of the bus clock, before any inversion is applied. The frame pulse is one bus-clock period wide and centred on that edge, so it is active for half a period on each side. The clock and the pulse each have a polarity input. A rate request is sampled only at the end of a frame, so every frame runs at a single rate from bit 0.

Top module: `tdm_frame_gen`

## Requirements
- R1: While reset is asserted, bit_pos is 0, frame_start and bit_strobe are 0, bus_clk equals clk_inv and frame_pulse equals the inverse of fp_inv. In both cases these are the inactive levels.
- R2: With the latched rate at 1, a bit period lasts 2 master cycles and a frame has 4096 bits. With the latched rate at 0, a bit period lasts 4 master cycles and a frame has 2048 bits. Either way a frame lasts 8192 master cycles, and bit_pos counts the bits from 0.
- R3: Before inversion, the bus clock is low for the first half of each bit period and high for the second half, so each bit begins on a falling edge. bit_strobe is high on the first master cycle of each bit period and low on the others.
- R4: With fp_inv at 0, frame_pulse is low for exactly one bus-clock period. That period is centred on the frame boundary: it covers the last half of the final bit and the first half of bit 0.
- R5: rate_fast is sampled only on the last master cycle of a frame. The next frame runs entirely at the sampled rate, starting from bit 0. A pulse that straddles a rate change is half an old period plus half a new period wide. A rate request that is withdrawn before the frame ends has no effect.
- R6: frame_start is high for exactly one master cycle, the first cycle of each frame after the first, and at that cycle bit_pos is 0.
- R7: clk_inv at 1 inverts bus_clk and fp_inv at 1 inverts frame_pulse, both without a register stage. Neither bit changes any timing.
- R8: After reset is released, rate_fast is captured on the first clock edge. The first frame gives no pulse until its closing boundary: the first pulse begins 8192 master cycles minus half a bit period after counting starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_fast | input | 1 | Rate request: 1 = 32.768 MHz bus clock, 0 = 16.384 MHz |
| clk_inv | input | 1 | Inverts bus_clk when 1 |
| fp_inv | input | 1 | Inverts frame_pulse when 1 |
| bus_clk | output | 1 | Bus clock |
| frame_pulse | output | 1 | 8 kHz frame pulse, active low by default |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| bit_strobe | output | 1 | One-cycle strobe at the start of each bit period |
| bit_pos | output | 12 | Index of the current bit within the frame |

## Verification
The hardest case to reach is a frame boundary where the rate changes, because there the pulse is built from two different half-periods. The stimulus switches the rate request in the middle of a frame, once towards the slow rate and once back, and checks the pulse width on each straddling boundary. A request that is raised and withdrawn within a frame shows that only the value present at the boundary counts. The polarity bits are flipped during a later frame while the scoreboard keeps measuring pulses, so an inversion that leaked into the timing would show up as a width or position mismatch.

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen #(
  parameter int BITS_FAST = 4096,
  parameter int BITS_SLOW = 2048,
  parameter int DIV_FAST  = 2,
  parameter int DIV_SLOW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_fast,
  input  logic          clk_inv,
  input  logic          fp_inv,
  output logic          bus_clk,
  output logic          frame_pulse,
  output logic          frame_start,
  output logic          bit_strobe,
  output logic [$clog2(BITS_FAST)-1:0] bit_pos
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int BW = $clog2(BITS_FAST);

  logic          live, armed, fast;
  logic [PW-1:0] ph, half, ph_end;
  logic [BW-1:0] bpos, b_end;
  logic          clk_hi, fp_act;

  assign half   = fast ? PW'(DIV_FAST / 2) : PW'(DIV_SLOW / 2);
  assign ph_end = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign b_end  = fast ? BW'(BITS_FAST - 1) : BW'(BITS_SLOW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      armed <= 1'b0;
      fast  <= 1'b0;
      ph    <= '0;
      bpos  <= '0;
    end else if (!live) begin
      live <= 1'b1;
      fast <= rate_fast;
    end else if (ph == ph_end) begin
      ph    <= '0;
      armed <= 1'b1;
      if (bpos == b_end) begin
        bpos <= '0;
        fast <= rate_fast;
      end else begin
        bpos <= bpos + 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign clk_hi = live && (ph >= half);
  assign fp_act = armed && (((bpos == b_end) && (ph >= half)) ||
                            ((bpos == '0) && (ph < half)));

  assign bus_clk     = clk_inv ^ clk_hi;
  assign frame_pulse = fp_inv ^ ~fp_act;
  assign frame_start = armed && (ph == '0) && (bpos == '0);
  assign bit_strobe  = live && (ph == '0);
  assign bit_pos     = bpos;
endmodule

// File: rtl/tdm_frame_gen_chk.sv
module tdm_frame_gen_chk #(
  parameter int BW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_inv,
  input logic          fp_inv,
  input logic          bus_clk,
  input logic          frame_pulse,
  input logic          frame_start,
  input logic          bit_strobe,
  input logic [BW-1:0] bit_pos
);
  logic clk_raw, fp_act;
  assign clk_raw = bus_clk ^ clk_inv;
  assign fp_act  = ~(frame_pulse ^ fp_inv);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!clk_raw && !fp_act && !frame_start && !bit_strobe && bit_pos == '0));

  assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  assert_pos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |-> $stable(bit_pos));

  assert_fall_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_raw) && !clk_raw && $stable(clk_inv)) |-> bit_strobe);

  assert_pulse_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fp_act);

  assert_start_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_strobe && bit_pos == '0));
endmodule

bind tdm_frame_gen tdm_frame_gen_chk #(.BW($clog2(BITS_FAST))) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_inv(clk_inv), .fp_inv(fp_inv),
  .bus_clk(bus_clk), .frame_pulse(frame_pulse), .frame_start(frame_start),
  .bit_strobe(bit_strobe), .bit_pos(bit_pos)
);

// File: tb/sim_tdm_frame_gen.sv
module sim_tdm_frame_gen;
  localparam int FRAME = 8192;

  logic        clk = 1'b0;
  logic        rst_n, rate_fast, clk_inv, fp_inv;
  logic        bus_clk, frame_pulse, frame_start, bit_strobe;
  logic [11:0] bit_pos;

  int    m = 0;
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  int    exp_start[$];
  int    exp_width[$];
  string exp_req[$];
  bit    sched[0:6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  always #10 clk = ~clk;

  tdm_frame_gen u0 (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .clk_inv(clk_inv),
    .fp_inv(fp_inv), .bus_clk(bus_clk), .frame_pulse(frame_pulse),
    .frame_start(frame_start), .bit_strobe(bit_strobe), .bit_pos(bit_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at m=%0d: actual=%0d expected=%0d", req, m, act, exp);
    end
  endtask

  task automatic push_pulse(input int j, input string req);
    int ho, hn;
    ho = sched[j-1] ? 1 : 2;
    hn = sched[j] ? 1 : 2;
    exp_start.push_back(j * FRAME - ho);
    exp_width.push_back(ho + hn);
    exp_req.push_back(req);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // driver
  initial begin
    rst_n = 1'b0; rate_fast = 1'b1; clk_inv = 1'b0; fp_inv = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(bus_clk == 1'b0, "R1 bus_clk", int'(bus_clk), 0);
      chk(frame_pulse == 1'b1, "R1 frame_pulse", int'(frame_pulse), 1);
      chk(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
      chk(bit_strobe == 1'b0, "R1 bit_strobe", int'(bit_strobe), 0);
      chk(bit_pos == 12'd0, "R1 bit_pos", int'(bit_pos), 0);
    end
    @(posedge clk); #3; clk_inv = 1'b1; fp_inv = 1'b1;
    @(negedge clk);
    chk(bus_clk == 1'b1, "R7 R1 inverted idle clock", int'(bus_clk), 1);
    chk(frame_pulse == 1'b0, "R7 R1 inverted idle pulse", int'(frame_pulse), 0);
    @(posedge clk); #3; clk_inv = 1'b0; fp_inv = 1'b0;

    push_pulse(1, "R8 first pulse");
    push_pulse(2, "R5 fast-to-slow boundary");
    push_pulse(3, "R4 slow pulse");
    push_pulse(4, "R5 slow-to-fast boundary");
    push_pulse(5, "R5 withdrawn request ignored");
    push_pulse(6, "R7 inverted polarity pulse");

    @(posedge clk); #3; rst_n = 1'b1;
    wait (m >= 9000);  #3; rate_fast = 1'b0;
    wait (m >= 25000); #3; rate_fast = 1'b1;
    wait (m >= 34000); #3; rate_fast = 1'b0;
    wait (m >= 34010); #3; rate_fast = 1'b1;
    wait (m >= 41500); #3; clk_inv = 1'b1;
    wait (m >= 42000); #3; fp_inv = 1'b1;
    @(negedge clk);
    chk(frame_pulse == 1'b0, "R7 idle pulse after fp_inv", int'(frame_pulse), 0);
    wait (m >= 6 * FRAME + 200);
    @(negedge clk);
    chk(exp_start.size() == 0, "R4 all pulses seen", exp_start.size(), 0);
    wrap_up();
  end

  // monitor / scoreboard
  initial begin
    bit in_p;
    int pstart;
    in_p = 1'b0;
    pstart = 0;
    wait (rst_n === 1'b1);
    @(posedge clk);
    m = 0;
    forever begin
      @(negedge clk);
      begin
        int f, dv, hf, r, ph, bp, w;
        bit act;
        f  = m / FRAME;
        if (f > 6) f = 6;
        dv = sched[f] ? 2 : 4;
        hf = dv / 2;
        r  = m % FRAME;
        ph = r % dv;
        bp = r / dv;
        chk(bus_clk == (clk_inv ^ (ph >= hf)), "R3 R7 bus_clk", int'(bus_clk),
            int'(clk_inv ^ (ph >= hf)));
        chk(bit_strobe == (ph == 0), "R3 bit_strobe", int'(bit_strobe), int'(ph == 0));
        chk(int'(bit_pos) == bp, "R2 bit_pos", int'(bit_pos), bp);
        chk(frame_start == (r == 0 && m >= FRAME), "R6 frame_start",
            int'(frame_start), int'(r == 0 && m >= FRAME));
        act = ~(frame_pulse ^ fp_inv);
        if (act && !in_p) begin
          in_p = 1'b1;
          pstart = m;
        end else if (!act && in_p) begin
          in_p = 1'b0;
          w = m - pstart;
          if (exp_start.size() == 0) begin
            chk(1'b0, "R4 unexpected pulse", pstart, -1);
          end else begin
            string rq;
            int es, ew;
            es = exp_start.pop_front();
            ew = exp_width.pop_front();
            rq = exp_req.pop_front();
            chk(pstart == es, {rq, " start"}, pstart, es);
            chk(w == ew, {rq, " width"}, w, ew);
          end
        end
      end
      @(posedge clk);
      m++;
    end
  end

  // watchdog
  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    wrap_up();
  end
endmodule